// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block forms the effective address of an indexed load inside a load/store path. One operation carries a 64-bit base value, a 64-bit index value, a 2-bit scale code and a 2-bit index-extension code. The index is first widened according to the extension code. It is then shifted left by the scale, which multiplies it by the element size. Finally the base is added. The unit has its own extender, shifter and adder, so it does not use the general integer ALU.

Operands arrive through a valid/ready handshake. The address leaves on registered outputs with a valid flag, exactly one clock after the operation is accepted. Every combination of modes takes this one cycle, so the extend-shift-add form costs no more than a plain base-plus-register address. With the input stream kept full, the unit accepts an operation every cycle. The memory access, translation, alignment checks and data return are handled elsewhere.

Top module: `scaled_index_agu`

## Requirements
- R1: The output address equals base + (extended index << scale). Scale code 0 shifts by 0 bits (byte), 1 by 1 bit (halfword), 2 by 2 bits (word) and 3 by 3 bits (doubleword).
- R2: Extension code 2'b00 uses the full 64-bit index unchanged.
- R3: Extension code 2'b01 sign-extends index bits [31:0] to 64 bits before the shift.
- R4: Extension code 2'b10 zero-extends index bits [31:0] to 64 bits before the shift. The unused code 2'b11 behaves like 2'b00.
- R5: The addition wraps modulo 2^64, and no carry or overflow indication is produced.
- R6: An operation accepted at a clock edge (in_valid and in_ready both high) appears on out_addr with out_valid high after that edge. This one-cycle latency is the same for every scale and extension code.
- R7: Operations accepted on consecutive edges produce valid results on consecutive cycles, each one carrying its own address.
- R8: While rst is high at a clock edge, out_valid, out_addr and in_ready are all 0 after that edge. in_ready returns to 1 after the first edge at which rst is low.
- R9: After an edge at which no operation was accepted, out_valid is 0 and out_addr is 0, so no stale address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the operand inputs |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_base | input | 64 | Base register value |
| in_index | input | 64 | Index register value |
| in_scale | input | 2 | Left-shift amount of 0 to 3 bits |
| in_ext | input | 2 | Index extension: 00 none, 01 sign word, 10 zero word, 11 as 00 |
| out_valid | output | 1 | out_addr holds a fresh result |
| out_addr | output | 64 | Effective address |

## Verification
Two things happen in the same cycle when the stream is full: a result is presented and the next operation is accepted. The bench provokes this by streaming the whole vector table without any gaps. Each result is compared, one cycle after its operation was accepted, with both the table's expected address and a multiply-based reference, so a result that was overwritten or shifted by a cycle does not match. A reset raised while in_valid is high is the second collision. It is judged by requiring that no valid flag and no address follow it.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SCALE_W = 2;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'b00,
    EXT_SWORD = 2'b01,
    EXT_ZWORD = 2'b10,
    EXT_RSVD  = 2'b11
  } ext_mode_e;
endpackage

// File: rtl/agu_index_extend.sv
module agu_index_extend
  import agu_pkg::*;
#(
  parameter int unsigned W  = ADDR_W,
  parameter int unsigned HW = WORD_W
) (
  input  logic [W-1:0] raw_idx,
  input  logic [1:0]   mode,
  output logic [W-1:0] ext_idx
);
  localparam int unsigned UPPER = W - HW;

  logic [HW-1:0] low_part;
  assign low_part = raw_idx[HW-1:0];

  always_comb begin
    unique case (ext_mode_e'(mode))
      EXT_SWORD: ext_idx = {{UPPER{low_part[HW-1]}}, low_part};
      EXT_ZWORD: ext_idx = {{UPPER{1'b0}}, low_part};
      default:   ext_idx = raw_idx;
    endcase
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int unsigned W   = 64,
  parameter int unsigned SCW = 2
) (
  input  logic [W-1:0]   idx,
  input  logic [SCW-1:0] shamt,
  output logic [W-1:0]   scaled
);
  localparam int unsigned NSHIFT = 1 << SCW;

  logic [W-1:0] cand [NSHIFT];

  for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
    if (s == 0) begin : g_pass
      assign cand[s] = idx;
    end else begin : g_sh
      assign cand[s] = {idx[W-1-s:0], {s{1'b0}}};
    end
  end

  assign scaled = cand[shamt];
endmodule

// File: rtl/agu_base_add.sv
module agu_base_add #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  output logic [W-1:0] sum
);
  assign sum = base + offset;
endmodule

// File: rtl/scaled_index_agu.sv
module scaled_index_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned HW  = WORD_W,
  parameter int unsigned SCW = SCALE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [AW-1:0]  in_base,
  input  logic [AW-1:0]  in_index,
  input  logic [SCW-1:0] in_scale,
  input  logic [1:0]     in_ext,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr
);
  localparam int unsigned UPPER = AW - HW;

  logic          ready_q;
  logic          accept;
  logic [AW-1:0] ext_idx;
  logic [AW-1:0] scaled_idx;
  logic [AW-1:0] sum_addr;

  assign in_ready = ready_q;
  assign accept   = in_valid & ready_q;

  agu_index_extend #(.W(AW), .HW(HW)) u_ext (
    .raw_idx (in_index),
    .mode    (in_ext),
    .ext_idx (ext_idx)
  );

  agu_index_scale #(.W(AW), .SCW(SCW)) u_scale (
    .idx    (ext_idx),
    .shamt  (in_scale),
    .scaled (scaled_idx)
  );

  agu_base_add #(.W(AW)) u_add (
    .base   (in_base),
    .offset (scaled_idx),
    .sum    (sum_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept;
      out_addr  <= accept ? sum_addr : '0;
    end
  end

  // Handshake timing: one cycle from acceptance to result
  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // Idle edge leaves nothing stale on the output
  assert_no_stale_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> (!out_valid && out_addr == '0));

  // Reset clears the output and drops ready
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready && out_addr == '0));

  // Sign-extended index has a uniform upper part matching bit HW-1
  assert_sext_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ext == EXT_SWORD) |->
      ($countones(ext_idx[AW-1:HW-1]) == 0 || $countones(ext_idx[AW-1:HW-1]) == UPPER + 1));

  // Zero-extended index has an all-zero upper part
  assert_zext_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ext == EXT_ZWORD) |-> (ext_idx[AW-1:HW] == '0));

  // Unscaled full-width index is a plain wrapping sum one cycle later
  assert_plain_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_ext == EXT_NONE && in_scale == '0)
      |=> (out_addr == $past(in_base) + $past(in_index)));
endmodule

// File: tb/tb_scaled_index_agu.sv
module tb_scaled_index_agu;
  typedef struct packed {
    logic [63:0] base;
    logic [63:0] idx;
    logic [1:0]  scale;
    logic [1:0]  ext;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{64'h1000, 64'h5, 2'd2, 2'b00, 64'h1014},                                       // R1 R2 word
    '{64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'b00, 64'h0FF8},                      // R2 negative index
    '{64'h1000, 64'h1234_5678_FFFF_FFFE, 2'd2, 2'b01, 64'h0FF8},                      // R3 sign word
    '{64'h1000, 64'h1234_5678_FFFF_FFFE, 2'd2, 2'b10, 64'h4_0000_0FF8},               // R4 zero word
    '{64'h0,    64'h8000_0000, 2'd0, 2'b01, 64'hFFFF_FFFF_8000_0000},                 // R3 byte
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 2'd1, 2'b00, 64'h10},                          // R5 wrap
    '{64'h100, 64'hAAAA_0000_0000_0003, 2'd1, 2'b11, 64'h5554_0000_0000_0106},        // R4 code 11
    '{64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 2'd1, 2'b00, 64'h0},          // R5 wrap to 0
    '{64'h2000, 64'h7FFF_FFFF, 2'd3, 2'b01, 64'h4_0000_1FF8},                         // R3 doubleword
    '{64'h55, 64'h1_0000_0003, 2'd0, 2'b10, 64'h58}                                   // R4 drops high bits
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_base;
  logic [63:0] in_index;
  logic [1:0]  in_scale;
  logic [1:0]  in_ext;
  logic        out_valid;
  logic [63:0] out_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  scaled_index_agu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_index(in_index), .in_scale(in_scale), .in_ext(in_ext),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [63:0] ref_addr(logic [63:0] b, logic [63:0] i,
                                           logic [1:0] s, logic [1:0] e);
    logic [63:0] x;
    case (e)
      2'b01:   x = 64'($signed(i[31:0]));
      2'b10:   x = {32'h0, i[31:0]};
      default: x = i;
    endcase
    return b + x * (64'd1 << s);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, vec_t t);
    in_valid = v;
    in_base  = t.base;
    in_index = t.idx;
    in_scale = t.scale;
    in_ext   = t.ext;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, VEC[0]);
    repeat (3) @(negedge clk);
    // R8: reset state even with an input offered
    check("R8 valid in reset", 64'(out_valid), 64'd0);
    check("R8 addr in reset", out_addr, 64'd0);
    check("R8 ready in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", 64'(in_ready), 64'd1);
    check("R9 idle valid", 64'(out_valid), 64'd0);

    // R7: whole table streamed back to back
    drive(1'b1, VEC[0]);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check("R6 R7 valid", 64'(out_valid), 64'd1);
      check("R1 table", out_addr, VEC[i].exp);
      check("R1 reference", out_addr,
            ref_addr(VEC[i].base, VEC[i].idx, VEC[i].scale, VEC[i].ext));
      if (i + 1 < NVEC) drive(1'b1, VEC[i+1]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R9 after stream valid", 64'(out_valid), 64'd0);
    check("R9 after stream addr", out_addr, 64'd0);

    // R6: isolated operations, every scale with sign extension
    for (int s = 0; s < 4; s++) begin
      vec_t t;
      t = '{64'h4000, 64'hFFFF_FFF0_FFFF_FFFC, 2'(s), 2'b01, 64'h0};
      drive(1'b1, t);
      @(negedge clk);
      in_valid = 1'b0;
      check("R6 R3 isolated", out_addr, ref_addr(t.base, t.idx, t.scale, t.ext));
      @(negedge clk);
      check("R9 gap", 64'(out_valid), 64'd0);
    end

    // R8: reset collides with an accepted operation
    drive(1'b1, VEC[3]);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset collision valid", 64'(out_valid), 64'd0);
    check("R8 reset collision addr", out_addr, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 ready back", 64'(in_ready), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule